// File: doc/BRIEF.md
# I2C Slave Transmitter with Clock Stretching

This block is the sending half of an I2C target. It watches the SCL and SDA lines through synchronizers clocked by the system clock, picks out START, repeated START and STOP conditions, and collects the eight bits of the address phase. When the seven address bits equal the `own_addr` input and the direction bit asks for a read, the block claims the bus. It then feeds the master bytes that software supplies one at a time through a write strobe.

A one-byte holding register sits in front of the output shift register. Software can load the next byte while the current one goes out. When no byte is ready at a point where one is needed, the block holds SCL low until software writes one. This applies to the acknowledge of the address itself, so the master does not see the address acknowledged before the first byte exists. Both lines are driven open-drain, as pull-down enables. Sticky status flags report what happened on the bus. Software clears them by writing ones to a clear strobe.

Top module: `i2c_tgt_sender`

## Requirements
- R1: After reset every status output is 0, and neither SCL nor SDA is pulled low.
- R2: An SDA fall while SCL is high sets the START flag (clear bit 3) and clears busy. An SDA rise while SCL is high clears busy; it sets the STOP flag (clear bit 4) only if busy was 1.
- R3: The address phase is eight bits, sampled on SCL rising edges and sent MSB first. The first seven bits are compared with `own_addr`, and the eighth is the direction bit, where 1 means read. A read to the block's own address sets busy, the transmit-mode flag (clear bit 0) and buffer-empty.
- R4: An address that does not match leaves busy at 0. SDA is not acknowledged (the master reads 1), and SCL is not stretched.
- R5: A matching address with direction bit 0 clears the transmit-mode flag. That address is not acknowledged, and busy stays 0.
- R6: After a matching read address, the block holds SCL low and withholds the ACK until software writes a byte. It then drives SDA low for the ninth clock.
- R7: A write with `tx_wr` is accepted only while buffer-empty is 1, and it clears buffer-empty. When the byte moves into the shift register, buffer-empty returns to 1. Writes while buffer-empty is 0 are ignored.
- R8: Data bits leave MSB first. The block changes SDA only while SCL is low.
- R9: A master ACK (SDA low in the ninth clock) with a byte waiting starts the next byte without stretching, and sets the byte-end flag (clear bit 1).
- R10: A master ACK with no byte waiting stretches SCL low until software writes one. That byte is the one sent next.
- R11: A master NACK (SDA high in the ninth clock) sets the NACK flag (clear bit 2). The block then releases SDA until the next START or STOP.
- R12: The flags for transmit mode, byte end, NACK, START and STOP are sticky. Writing 1 to the matching `flag_clr` bit clears a flag, and a hardware set in the same cycle wins. Busy and buffer-empty are changed only by hardware.
- R13: A repeated START during a transfer ends it, clears busy and buffer-empty, sets the START flag, and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address the block answers to |
| scl_i | input | 1 | Level of the SCL line |
| sda_i | input | 1 | Level of the SDA line |
| scl_pull_o | output | 1 | 1 pulls SCL low (stretch) |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| tx_wr | input | 1 | Write strobe for the holding register |
| tx_byte | input | 8 | Byte to transmit |
| flag_clr | input | 5 | Write-one-to-clear: bit0 tmode, bit1 byte end, bit2 NACK, bit3 START, bit4 STOP |
| busy_o | output | 1 | A read transfer to this address is in progress |
| bempty_o | output | 1 | Holding register can take a byte |
| tmode_o | output | 1 | Last matching address was a read |
| bend_o | output | 1 | Byte end flag |
| nack_o | output | 1 | Master NACK flag |
| start_o | output | 1 | START seen flag |
| stop_o | output | 1 | STOP seen flag |

## Verification
Some properties are checked on every cycle:
- SDA stays stable while the synchronized SCL is high.
- A stretch only begins after a cycle in which the buffer was empty.
- Buffer-empty implies busy.
- SDA is never pulled while not busy.
- The STOP flag and busy react to a STOP.
- The clear strobes are honoured and the flags stay sticky.

Other behaviour only the bench scenarios can show:
- The byte order and values on the bus.
- That the address ACK is withheld until the first write.
- That no stretch occurs when a byte is already waiting.
- That ignored writes never reach the bus.
- How NACK, a non-matching address, a write-direction address and a repeated START play out.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

   localparam int FLG_TMODE = 0;
   localparam int FLG_BEND  = 1;
   localparam int FLG_NACK  = 2;
   localparam int FLG_START = 3;
   localparam int FLG_STOP  = 4;
   localparam int NUM_FLAGS = 5;

   typedef enum logic [2:0] {
      S_IDLE,
      S_ADDR,
      S_AACK,
      S_LOAD,
      S_ACKO,
      S_DATA,
      S_MACK,
      S_WAIT
   } tx_state_e;

endpackage

// File: rtl/i2c_tgt_linesync.sv
module i2c_tgt_linesync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic scl_lvl,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_cond,
   output logic stop_cond
);

   localparam int NLINES = 2;

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_tgt_linesync: STAGES must be at least 2");
   end

   logic [NLINES-1:0] raw;
   logic [NLINES-1:0] lvl;
   logic [NLINES-1:0] prv;

   assign raw = {sda_in, scl_in};

   for (genvar g = 0; g < NLINES; g++) begin : g_line
      logic [STAGES:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe <= '1;
         else        pipe <= {pipe[STAGES-1:0], raw[g]};
      end
      assign lvl[g] = pipe[STAGES-1];
      assign prv[g] = pipe[STAGES];
   end

   assign scl_lvl    = lvl[0];
   assign sda_lvl    = lvl[1];
   assign scl_rise   = lvl[0] & ~prv[0];
   assign scl_fall   = ~lvl[0] & prv[0];
   assign start_cond = lvl[0] & prv[0] & prv[1] & ~lvl[1];
   assign stop_cond  = lvl[0] & prv[0] & ~prv[1] & lvl[1];

endmodule

// File: rtl/i2c_tgt_txbuf.sv
module i2c_tgt_txbuf #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wr_data,
   input  logic         arm,
   input  logic         take,
   input  logic         drop,
   output logic         empty,
   output logic [W-1:0] hold_q
);

   if (W < 1) begin : g_bad_w
      $error("i2c_tgt_txbuf: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         empty  <= 1'b0;
         hold_q <= '0;
      end else if (drop) begin
         empty <= 1'b0;
      end else if (arm || take) begin
         empty <= 1'b1;
      end else if (wr_en && empty) begin
         hold_q <= wr_data;
         empty  <= 1'b0;
      end
   end

   AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && empty && !drop && !arm && !take) |=> !empty); // R7

   AST_TAKE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      take |-> !empty); // R7

endmodule

// File: rtl/i2c_tgt_flags.sv
module i2c_tgt_flags #(
   parameter int N = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] hw_clr,
   input  logic [N-1:0] sw_clr,
   output logic [N-1:0] flags
);

   for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      flags[i] <= 1'b0;
         else if (set[i])                 flags[i] <= 1'b1;
         else if (hw_clr[i] || sw_clr[i]) flags[i] <= 1'b0;
      end

      AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (sw_clr[i] && !set[i]) |=> !flags[i]); // R12

      AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[i] && !sw_clr[i] && !hw_clr[i]) |=> flags[i]); // R12
   end

endmodule

// File: rtl/i2c_tgt_sender.sv
module i2c_tgt_sender
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W       = 7,
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int STRETCH_TAIL = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_pull_o,
   output logic              sda_pull_o,
   input  logic              tx_wr,
   input  logic [DATA_W-1:0] tx_byte,
   input  logic [NUM_FLAGS-1:0] flag_clr,
   output logic              busy_o,
   output logic              bempty_o,
   output logic              tmode_o,
   output logic              bend_o,
   output logic              nack_o,
   output logic              start_o,
   output logic              stop_o
);

   localparam int CNT_W  = $clog2(DATA_W);
   localparam int TAIL_W = $clog2(STRETCH_TAIL + 1);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   if (ADDR_W + 1 != DATA_W) begin : g_bad_addr
      $error("i2c_tgt_sender: address plus direction bit must fill one byte");
   end
   if (STRETCH_TAIL < 1) begin : g_bad_tail
      $error("i2c_tgt_sender: STRETCH_TAIL must be at least 1");
   end

   logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;

   i2c_tgt_linesync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_in     (scl_i),
      .sda_in     (sda_i),
      .scl_lvl    (scl_lvl),
      .sda_lvl    (sda_lvl),
      .scl_rise   (scl_rise),
      .scl_fall   (scl_fall),
      .start_cond (start_c),
      .stop_cond  (stop_c)
   );

   logic              tx_empty, tx_arm, tx_take, tx_drop;
   logic [DATA_W-1:0] tx_hold;

   i2c_tgt_txbuf #(.W(DATA_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tx_wr),
      .wr_data (tx_byte),
      .arm     (tx_arm),
      .take    (tx_take),
      .drop    (tx_drop),
      .empty   (tx_empty),
      .hold_q  (tx_hold)
   );

   logic [NUM_FLAGS-1:0] fl_set, fl_hwclr, fl_q;

   i2c_tgt_flags #(.N(NUM_FLAGS)) u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .set    (fl_set),
      .hw_clr (fl_hwclr),
      .sw_clr (flag_clr),
      .flags  (fl_q)
   );

   tx_state_e         st_q, st_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [DATA_W-1:0] sh_q, sh_d;
   logic [ADDR_W-1:0] adr_q, adr_d;
   logic [TAIL_W-1:0] tail_q, tail_d;
   logic              mbit_q, mbit_d;
   logic              rack_q, rack_d;
   logic              busy_q, busy_d;

   always_comb begin
      st_d     = st_q;
      cnt_d    = cnt_q;
      sh_d     = sh_q;
      adr_d    = adr_q;
      mbit_d   = mbit_q;
      rack_d   = rack_q;
      busy_d   = busy_q;
      tail_d   = (tail_q != '0) ? tail_q - 1'b1 : tail_q;
      tx_arm   = 1'b0;
      tx_take  = 1'b0;
      tx_drop  = 1'b0;
      fl_set   = '0;
      fl_hwclr = '0;
      if (start_c) begin
         st_d   = S_ADDR;
         cnt_d  = '0;
         busy_d = 1'b0;
         tail_d = '0;
         tx_drop = 1'b1;
         fl_set[FLG_START] = 1'b1;
      end else if (stop_c) begin
         st_d   = S_IDLE;
         busy_d = 1'b0;
         tail_d = '0;
         tx_drop = 1'b1;
         fl_set[FLG_STOP] = busy_q;
      end else begin
         unique case (st_q)
            S_ADDR: if (scl_rise) begin
               adr_d = {adr_q[ADDR_W-2:0], sda_lvl};
               cnt_d = cnt_q + 1'b1;
               if (cnt_q == LAST_BIT) begin
                  st_d = S_WAIT;
                  if (adr_q == own_addr) begin
                     if (sda_lvl) begin
                        fl_set[FLG_TMODE] = 1'b1;
                        busy_d = 1'b1;
                        tx_arm = 1'b1;
                        st_d   = S_AACK;
                     end else begin
                        fl_hwclr[FLG_TMODE] = 1'b1;
                     end
                  end
               end
            end
            S_AACK: if (scl_fall) begin
               if (!tx_empty) begin
                  tx_take = 1'b1;
                  sh_d    = tx_hold;
                  st_d    = S_ACKO;
               end else begin
                  rack_d = 1'b1;
                  st_d   = S_LOAD;
               end
            end
            S_LOAD: if (!tx_empty) begin
               tx_take = 1'b1;
               sh_d    = tx_hold;
               cnt_d   = '0;
               tail_d  = TAIL_W'(STRETCH_TAIL);
               st_d    = rack_q ? S_ACKO : S_DATA;
            end
            S_ACKO: if (scl_fall) begin
               st_d  = S_DATA;
               cnt_d = '0;
            end
            S_DATA: if (scl_fall) begin
               sh_d  = {sh_q[DATA_W-2:0], 1'b0};
               cnt_d = cnt_q + 1'b1;
               if (cnt_q == LAST_BIT) st_d = S_MACK;
            end
            S_MACK: if (scl_rise) begin
               mbit_d = sda_lvl;
            end else if (scl_fall) begin
               if (mbit_q) begin
                  fl_set[FLG_NACK] = 1'b1;
                  st_d = S_WAIT;
               end else begin
                  fl_set[FLG_BEND] = 1'b1;
                  if (!tx_empty) begin
                     tx_take = 1'b1;
                     sh_d    = tx_hold;
                     cnt_d   = '0;
                     st_d    = S_DATA;
                  end else begin
                     rack_d = 1'b0;
                     st_d   = S_LOAD;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         cnt_q  <= '0;
         sh_q   <= '0;
         adr_q  <= '0;
         tail_q <= '0;
         mbit_q <= 1'b0;
         rack_q <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         cnt_q  <= cnt_d;
         sh_q   <= sh_d;
         adr_q  <= adr_d;
         tail_q <= tail_d;
         mbit_q <= mbit_d;
         rack_q <= rack_d;
         busy_q <= busy_d;
      end
   end

   assign scl_pull_o = (st_q == S_LOAD) || (tail_q != '0);
   assign sda_pull_o = (st_q == S_ACKO) || ((st_q == S_DATA) && !sh_q[DATA_W-1]);

   assign busy_o   = busy_q;
   assign bempty_o = tx_empty;
   assign tmode_o  = fl_q[FLG_TMODE];
   assign bend_o   = fl_q[FLG_BEND];
   assign nack_o   = fl_q[FLG_NACK];
   assign start_o  = fl_q[FLG_START];
   assign stop_o   = fl_q[FLG_STOP];

   AST_SDA_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_lvl && $past(scl_lvl)) |-> $stable(sda_pull_o)); // R8

   AST_STRETCH_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(scl_pull_o) |-> $past(tx_empty)); // R10

   AST_EMPTY_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tx_empty |-> busy_q); // R13

   AST_NO_DRIVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sda_pull_o); // R4

   AST_STOP_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_c && busy_q) |=> (stop_o && !busy_o)); // R2

endmodule

// File: tb/test_i2c_tgt_sender.sv
`timescale 1ns/1ps
module test_i2c_tgt_sender;

   localparam int HALF = 10;
   localparam logic [6:0] OWN = 7'h5A;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic       rst_n = 1'b0;
   logic       m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic       scl_bus, sda_bus, scl_pull, sda_pull;
   logic       tx_wr = 1'b0;
   logic [7:0] tx_byte = '0;
   logic [4:0] flag_clr = '0;
   logic       busy, bempty, tmode, bend, nack, startf, stopf;

   assign scl_bus = !(m_scl_low || scl_pull);
   assign sda_bus = !(m_sda_low || sda_pull);

   i2c_tgt_sender i_i2c_tgt_sender (
      .clk(clk), .rst_n(rst_n), .own_addr(OWN),
      .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
      .tx_wr(tx_wr), .tx_byte(tx_byte), .flag_clr(flag_clr),
      .busy_o(busy), .bempty_o(bempty), .tmode_o(tmode), .bend_o(bend),
      .nack_o(nack), .start_o(startf), .stop_o(stopf)
   );

   int n_chk = 0, n_fail = 0;
   int stretch_cyc = 0, sda_viol = 0;
   logic prev_scl = 1'b1, prev_pull = 1'b0;
   logic [7:0] exp_q[$];

   // per-clock line model: slave SDA may only move while the bus SCL is low
   always @(negedge clk) begin
      if (rst_n) begin
         if (scl_pull) stretch_cyc++;
         if (scl_bus && prev_scl && (sda_pull !== prev_pull)) sda_viol++;
      end
      prev_scl  = scl_bus;
      prev_pull = sda_pull;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_scl_high();
      while (!scl_bus) tick(1);
   endtask

   task automatic m_start();
      tick(2); m_sda_low = 1'b0; tick(HALF);
      m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
      m_sda_low = 1'b1; tick(HALF);
      m_scl_low = 1'b1;
   endtask

   task automatic m_stop();
      tick(2); m_sda_low = 1'b1; tick(HALF);
      m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
      m_sda_low = 1'b0; tick(HALF);
   endtask

   task automatic m_put_bit(input logic b);
      tick(2); m_sda_low = !b; tick(HALF);
      m_scl_low = 1'b0; wait_scl_high(); tick(HALF);
      m_scl_low = 1'b1;
   endtask

   task automatic m_get_bit(output logic b);
      tick(2); m_sda_low = 1'b0; tick(HALF);
      m_scl_low = 1'b0; wait_scl_high(); tick(HALF/2);
      b = sda_bus; tick(HALF/2);
      m_scl_low = 1'b1;
   endtask

   task automatic m_put_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) m_put_bit(v[i]);
   endtask

   task automatic m_get_byte(output logic [7:0] v);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         m_get_bit(b);
         v[i] = b;
      end
   endtask

   task automatic sw_write(input logic [7:0] d, input logic accept);
      tx_wr = 1'b1; tx_byte = d;
      if (accept) exp_q.push_back(d);
      tick(1);
      tx_wr = 1'b0;
   endtask

   task automatic sw_clear(input logic [4:0] m);
      flag_clr = m; tick(1); flag_clr = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      logic       ack;
      logic [7:0] got;
      int         s0;
      tick(5); rst_n = 1'b1; tick(3);
      chk("R1 status after reset", {busy, bempty, tmode, bend, nack, startf, stopf}, 7'h00);
      chk("R1 pulls after reset", {scl_pull, sda_pull}, 2'b00);
      sw_write(8'hAA, 1'b0);          // R7: ignored, buffer not armed

      // non-matching read address
      s0 = stretch_cyc;
      m_start();
      m_put_byte({7'h33, 1'b1});
      m_get_bit(ack);
      chk("R4 foreign address not acked", ack, 1);
      chk("R4 busy stays 0", busy, 0);
      chk("R4 no stretch", stretch_cyc - s0, 0);
      chk("R2 start flag", startf, 1);
      m_stop(); tick(4);
      chk("R2 stop flag only when busy", stopf, 0);
      sw_clear(5'b01000);
      chk("R12 start flag cleared by w1c", startf, 0);

      // matching read, first byte held back
      m_start();
      m_put_byte({OWN, 1'b1});
      chk("R3 busy on read match", busy, 1);
      chk("R3 tmode on read match", tmode, 1);
      chk("R3 buffer empty on read match", bempty, 1);
      fork
         m_get_bit(ack);
         begin
            tick(60);
            chk("R6 scl stretched before first byte", scl_pull, 1);
            chk("R6 ack withheld", sda_pull, 0);
            sw_write(8'h96, 1'b1);
         end
      join
      chk("R6 address acked after write", ack, 0);
      chk("R7 byte moved, buffer empty again", bempty, 1);
      fork
         m_get_byte(got);
         begin
            tick(30);
            sw_write(8'h3C, 1'b1);
            chk("R7 write clears buffer empty", bempty, 0);
            sw_write(8'h11, 1'b0);
         end
      join
      chk("R8 first byte MSB first", got, exp_q.pop_front());
      s0 = stretch_cyc;
      m_put_bit(1'b0);
      tick(4);
      chk("R9 byte end flag on ack", bend, 1);
      m_get_byte(got);
      chk("R9 next byte, ignored write absent (R7)", got, exp_q.pop_front());
      chk("R9 no stretch with byte waiting", stretch_cyc - s0, 0);
      sw_clear(5'b00010);
      chk("R12 byte end cleared", bend, 0);
      m_put_bit(1'b0);
      fork
         m_get_byte(got);
         begin
            tick(50);
            chk("R10 stretch when buffer empty", scl_pull, 1);
            sw_write(8'hC3, 1'b1);
         end
      join
      chk("R10 byte after stretch", got, exp_q.pop_front());
      m_put_bit(1'b1);
      tick(4);
      chk("R11 nack flag", nack, 1);
      m_get_byte(got);
      chk("R11 sda released after nack", got, 8'hFF);
      m_stop(); tick(4);
      chk("R2 stop clears busy", busy, 0);
      chk("R2 stop flag set while busy", stopf, 1);
      chk("R13 stop clears buffer empty", bempty, 0);
      chk("R12 tmode sticky", tmode, 1);
      sw_clear(5'b11111);
      chk("R12 all flags cleared", {tmode, bend, nack, startf, stopf}, 5'h00);

      // repeated start mid-transfer, then write-direction address
      m_start();
      m_put_byte({OWN, 1'b1});
      sw_write(8'h81, 1'b1);
      m_get_bit(ack);
      chk("R6 ack with byte ready", ack, 0);
      m_get_byte(got);
      chk("R8 byte before repeated start", got, exp_q.pop_front());
      m_start(); tick(4);
      chk("R13 start flag on repeated start", startf, 1);
      chk("R13 busy cleared", busy, 0);
      chk("R13 buffer empty cleared", bempty, 0);
      m_put_byte({OWN, 1'b0});
      m_get_bit(ack);
      chk("R5 write address not acked", ack, 1);
      chk("R5 tmode cleared", tmode, 0);
      chk("R5 busy stays 0", busy, 0);
      m_stop(); tick(4);
      chk("R8 sda never changed while scl high", sda_viol, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule